// File: doc/BRIEF.md
# Fault-Injecting Bit RAM

This block is a single-port, one-bit-wide RAM that can be told to misbehave in a controlled way. A built-in self-test controller that runs march sequences is connected to its memory port. A test program loads one fault description through a small configuration port. The controller under test should then report the fault. With no fault loaded, the block behaves as an ideal RAM with a registered read.

Each fault description has four parts: a fault class, a victim address, an aggressor address, and two option bits. The option bits are a transition direction and a forced value. The supported classes are:

- a stuck cell,
- an up or down transition fault,
- an inversion coupling fault,
- an idempotent coupling fault,
- an AND or OR bridge between two cells,
- an address-decoder alias.

In the alias class, the victim address is decoded onto the aggressor cell. The fault is applied by remapping the address before the array, so reads and writes see the same faulty decoder. The remapping is purely combinational.

Top module: `faulty_bit_ram`

## Requirements
- R1: After reset every cell holds 0, the read output is 0 and the fault class is none (code 0).
- R2: With class 0 a write stores the write bit in the addressed cell. A read returns the addressed cell one clock after the edge that samples it. The read output keeps its value in every cycle without a read (mem_en low, or mem_we high).
- R3: With class 1 (stuck), a read of the victim returns cfg_val whatever was written. A write to the victim stores cfg_val.
- R4: With class 2 (up transition), a write of 1 to the victim while it holds 0 leaves it at 0. Other writes behave normally.
- R5: With class 3 (down transition), a write of 0 to the victim while it holds 1 leaves it at 1. Other writes behave normally.
- R6: With class 4 (inversion coupling), a write that changes the aggressor cell inverts the victim cell in the same edge. The change must be rising when cfg_fall is 0 and falling when cfg_fall is 1. A write that leaves the aggressor unchanged does not disturb the victim.
- R7: With class 5 (idempotent coupling), a write that changes the aggressor in the configured direction (cfg_fall as in R6) sets the victim to cfg_val. All four direction and value combinations are selectable.
- R8: With class 6 (AND bridge), a read of either the victim or the aggressor returns the AND of both cells. With class 7 (OR bridge), it returns their OR. Reads of other addresses and all writes are unaffected.
- R9: With class 8 (alias), reads and writes to the victim address reach the aggressor cell. The victim cell keeps its content while the alias is active.
- R10: A pulse on cfg_load captures the class, addresses and option bits, which take effect from the next edge. Cell contents are kept across configuration changes. Class codes above 8 load as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | input | 1 | Access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Access address |
| mem_wbit | input | 1 | Write data bit |
| mem_rbit | output | 1 | Registered read data |
| cfg_load | input | 1 | Capture the fault description |
| cfg_kind | input | 4 | Fault class code (0 to 8) |
| cfg_fall | input | 1 | Coupling trigger direction: 0 rising, 1 falling |
| cfg_val | input | 1 | Stuck or forced value |
| cfg_victim | input | ADDR_W | Victim (coupled or aliased) address |
| cfg_aggr | input | ADDR_W | Aggressor (coupling, bridge partner or alias target) address |

## Verification
The hardest situations to reach from the ports are the coupling faults. A victim only changes when a write moves the aggressor in the configured direction, so the victim's disturbance is visible only through a later read. The stimulus therefore writes the aggressor several times in a row: once with no change, once in the non-triggering direction, and once in the triggering direction. It reads the victim after each of these writes, and repeats the sequence with the opposite direction and forced value. The alias case is reached the same way. The victim cell is preloaded with the ideal class, the alias is applied, the aliased address is written, and the alias is then removed so that the untouched victim content can be read back.

// File: rtl/fr_pkg.sv
package fr_pkg;

   typedef enum logic [3:0] {
      FK_NONE   = 4'd0,
      FK_STUCK  = 4'd1,
      FK_TF_UP  = 4'd2,
      FK_TF_DN  = 4'd3,
      FK_CF_INV = 4'd4,
      FK_CF_ID  = 4'd5,
      FK_BR_AND = 4'd6,
      FK_BR_OR  = 4'd7,
      FK_ALIAS  = 4'd8
   } fault_kind_e;

   localparam logic [3:0] FK_LAST = 4'd8;

   typedef struct packed {
      fault_kind_e kind;
      logic        fall;
      logic        val;
   } fault_mode_t;

endpackage

// File: rtl/fr_cfg_regs.sv
module fr_cfg_regs
   import fr_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [3:0]        kind_code,
   input  logic              fall,
   input  logic              val,
   input  logic [ADDR_W-1:0] victim,
   input  logic [ADDR_W-1:0] aggr,
   output fault_mode_t       mode_q,
   output logic [ADDR_W-1:0] victim_q,
   output logic [ADDR_W-1:0] aggr_q
);

   fault_kind_e kind_dec;

   always_comb begin
      if (kind_code > FK_LAST) kind_dec = FK_NONE;
      else                     kind_dec = fault_kind_e'(kind_code);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '{kind: FK_NONE, fall: 1'b0, val: 1'b0};
         victim_q <= '0;
         aggr_q   <= '0;
      end else if (load) begin
         mode_q   <= '{kind: kind_dec, fall: fall, val: val};
         victim_q <= victim;
         aggr_q   <= aggr;
      end
   end

endmodule

// File: rtl/fr_addr_map.sv
module fr_addr_map
   import fr_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  fault_mode_t       mode,
   input  logic [ADDR_W-1:0] victim,
   input  logic [ADDR_W-1:0] aggr,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] phys
);

   // Same remap feeds read and write paths: decoder fault is symmetric
   always_comb begin
      if (mode.kind == FK_ALIAS && addr == victim) phys = aggr;
      else                                         phys = addr;
   end

endmodule

// File: rtl/fr_fault_logic.sv
module fr_fault_logic
   import fr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 64
) (
   input  fault_mode_t       mode,
   input  logic [ADDR_W-1:0] victim,
   input  logic [ADDR_W-1:0] aggr,
   input  logic [ADDR_W-1:0] phys,
   input  logic              wbit,
   input  logic [DEPTH-1:0]  cells,
   output logic              store_bit,
   output logic              cpl_en,
   output logic              cpl_bit,
   output logic              rd_bit
);

   logic old_bit, vic_bit, agg_bit;
   logic hit_vic, hit_agg, moved, dir_ok;

   always_comb begin
      old_bit = cells[phys];
      vic_bit = cells[victim];
      agg_bit = cells[aggr];
      hit_vic = (phys == victim);
      hit_agg = (phys == aggr) && (aggr != victim);
      moved   = (old_bit != wbit);
      dir_ok  = mode.fall ? old_bit : wbit;
   end

   // Value actually stored by a write to phys
   always_comb begin
      store_bit = wbit;
      unique case (mode.kind)
         FK_STUCK:  if (hit_vic)                      store_bit = mode.val;
         FK_TF_UP:  if (hit_vic && !old_bit && wbit)  store_bit = 1'b0;
         FK_TF_DN:  if (hit_vic && old_bit && !wbit)  store_bit = 1'b1;
         default:   store_bit = wbit;
      endcase
   end

   // Side effect on the victim when the aggressor makes a transition
   always_comb begin
      cpl_en  = 1'b0;
      cpl_bit = vic_bit;
      if (hit_agg && moved && dir_ok) begin
         if (mode.kind == FK_CF_INV) begin
            cpl_en  = 1'b1;
            cpl_bit = ~vic_bit;
         end else if (mode.kind == FK_CF_ID) begin
            cpl_en  = 1'b1;
            cpl_bit = mode.val;
         end
      end
   end

   // Read path: stuck override and state-triggered bridges
   always_comb begin
      rd_bit = old_bit;
      if (mode.kind == FK_STUCK && hit_vic)
         rd_bit = mode.val;
      else if (mode.kind == FK_BR_AND && (hit_vic || phys == aggr))
         rd_bit = vic_bit & agg_bit;
      else if (mode.kind == FK_BR_OR && (hit_vic || phys == aggr))
         rd_bit = vic_bit | agg_bit;
   end

endmodule

// File: rtl/fr_cell_array.sv
module fr_cell_array #(
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_bit,
   input  logic              cpl_en,
   input  logic [ADDR_W-1:0] cpl_addr,
   input  logic              cpl_bit,
   output logic [DEPTH-1:0]  cells
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[g] <= 1'b0;
         else if (wr_en && wr_addr == MY_ADDR)
            cells[g] <= wr_bit;
         else if (cpl_en && cpl_addr == MY_ADDR)
            cells[g] <= cpl_bit;
      end
   end

endmodule

// File: rtl/faulty_bit_ram.sv
module faulty_bit_ram
   import fr_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_en,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_wbit,
   output logic              mem_rbit,
   input  logic              cfg_load,
   input  logic [3:0]        cfg_kind,
   input  logic              cfg_fall,
   input  logic              cfg_val,
   input  logic [ADDR_W-1:0] cfg_victim,
   input  logic [ADDR_W-1:0] cfg_aggr
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
      $error("faulty_bit_ram: ADDR_W must lie in 1..10");
   end

   fault_mode_t       mode_q;
   logic [ADDR_W-1:0] victim_q, aggr_q, phys;
   logic [DEPTH-1:0]  cells;
   logic              store_bit, cpl_en, cpl_bit, rd_bit;
   logic              wr_go;

   fr_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .kind_code(cfg_kind),
      .fall     (cfg_fall),
      .val      (cfg_val),
      .victim   (cfg_victim),
      .aggr     (cfg_aggr),
      .mode_q   (mode_q),
      .victim_q (victim_q),
      .aggr_q   (aggr_q)
   );

   fr_addr_map #(.ADDR_W(ADDR_W)) u_map (
      .mode  (mode_q),
      .victim(victim_q),
      .aggr  (aggr_q),
      .addr  (mem_addr),
      .phys  (phys)
   );

   fr_fault_logic #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_flt (
      .mode     (mode_q),
      .victim   (victim_q),
      .aggr     (aggr_q),
      .phys     (phys),
      .wbit     (mem_wbit),
      .cells    (cells),
      .store_bit(store_bit),
      .cpl_en   (cpl_en),
      .cpl_bit  (cpl_bit),
      .rd_bit   (rd_bit)
   );

   assign wr_go = mem_en & mem_we;

   fr_cell_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_go),
      .wr_addr (phys),
      .wr_bit  (store_bit),
      .cpl_en  (cpl_en & wr_go),
      .cpl_addr(victim_q),
      .cpl_bit (cpl_bit),
      .cells   (cells)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mem_rbit <= 1'b0;
      else if (mem_en && !mem_we) mem_rbit <= rd_bit;
   end

endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_wbit,
   input logic              mem_rbit,
   input logic [3:0]        kind,
   input logic              val,
   input logic [ADDR_W-1:0] victim,
   input logic [DEPTH-1:0]  cells
);

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_en && !mem_we) |=> $stable(mem_rbit)); // R2

   AST_IDEAL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 4'd0 && mem_en && mem_we) |=> cells[$past(mem_addr)] == $past(mem_wbit)); // R2

   AST_STUCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 4'd1 && mem_en && !mem_we && mem_addr == victim) |=> mem_rbit == $past(val)); // R3

   AST_TF_UP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 4'd2 && mem_en && mem_we && mem_addr == victim && !cells[victim])
      |=> !cells[$past(victim)]); // R4

   AST_TF_DN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 4'd3 && mem_en && mem_we && mem_addr == victim && cells[victim])
      |=> cells[$past(victim)]); // R5

   AST_ALIAS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 4'd8) |=> cells[$past(victim)] == $past(cells[victim])); // R9

endmodule

bind faulty_bit_ram fr_chk #(.ADDR_W(ADDR_W), .DEPTH(1 << ADDR_W)) u_fr_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mem_en  (mem_en),
   .mem_we  (mem_we),
   .mem_addr(mem_addr),
   .mem_wbit(mem_wbit),
   .mem_rbit(mem_rbit),
   .kind    (mode_q.kind),
   .val     (mode_q.val),
   .victim  (victim_q),
   .cells   (cells)
);

// File: tb/test_faulty_bit_ram.sv
module test_faulty_bit_ram;

   localparam int  AW   = 6;
   localparam int  N    = 1 << AW;
   localparam time TCLK = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic mem_en = 1'b0, mem_we = 1'b0, mem_wbit = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic mem_rbit;
   logic cfg_load = 1'b0, cfg_fall = 1'b0, cfg_val = 1'b0;
   logic [3:0] cfg_kind = '0;
   logic [AW-1:0] cfg_victim = '0, cfg_aggr = '0;

   faulty_bit_ram #(.ADDR_W(AW)) i_faulty_bit_ram (
      .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wbit(mem_wbit), .mem_rbit(mem_rbit),
      .cfg_load(cfg_load), .cfg_kind(cfg_kind), .cfg_fall(cfg_fall),
      .cfg_val(cfg_val), .cfg_victim(cfg_victim), .cfg_aggr(cfg_aggr)
   );

   always #(TCLK/2) clk = ~clk;

   int    errors = 0, checks = 0;
   string req = "R1";
   bit    running = 0;

   // Behavioural reference model
   bit m [N];
   int mk = 0, mvic = 0, magg = 0, ma = 0;
   bit mfall = 0, mval = 0, mrd = 0, mo = 0, mn = 0, mr = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m[i]) m[i] = 0;
         mk = 0; mvic = 0; magg = 0; mfall = 0; mval = 0; mrd = 0;
      end else begin
         if (mem_en) begin
            ma = int'(mem_addr);
            if (mk == 8 && ma == mvic) ma = magg;
            if (mem_we) begin
               mo = m[ma]; mn = mem_wbit;
               if (mk == 1 && ma == mvic) mn = mval;
               if (mk == 2 && ma == mvic && !mo && mn) mn = 0;
               if (mk == 3 && ma == mvic && mo && !mn) mn = 1;
               if ((mk == 4 || mk == 5) && ma == magg && magg != mvic && mo != mn && (mfall ? mo : mn))
                  m[mvic] = (mk == 4) ? !m[mvic] : mval;
               m[ma] = mn;
            end else begin
               mr = m[ma];
               if (mk == 1 && ma == mvic) mr = mval;
               if ((mk == 6 || mk == 7) && (ma == mvic || ma == magg))
                  mr = (mk == 6) ? (m[mvic] & m[magg]) : (m[mvic] | m[magg]);
               mrd = mr;
            end
         end
         if (cfg_load) begin
            mk = (cfg_kind > 4'd8) ? 0 : int'(cfg_kind);
            mvic = int'(cfg_victim); magg = int'(cfg_aggr);
            mfall = cfg_fall; mval = cfg_val;
         end
      end
   end

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (running) begin
         checks++;
         if (mem_rbit !== mrd) begin
            errors++;
            $display("FAIL %s: cycle compare rdata=%0b expected=%0b", req, mem_rbit, mrd);
         end
      end
   end

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rdata=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic b);
      @(negedge clk);
      mem_en = 1; mem_we = 1; mem_addr = AW'(a); mem_wbit = b;
      @(posedge clk); #1;
      mem_en = 0; mem_we = 0;
   endtask

   task automatic rd(input int a, input logic exp, input string tag);
      @(negedge clk);
      mem_en = 1; mem_we = 0; mem_addr = AW'(a);
      @(posedge clk); #1;
      mem_en = 0;
      check(mem_rbit, exp, tag);
   endtask

   task automatic setcfg(input int k, input logic f, input logic v, input int vic, input int agg);
      @(negedge clk);
      cfg_load = 1; cfg_kind = 4'(k); cfg_fall = f; cfg_val = v;
      cfg_victim = AW'(vic); cfg_aggr = AW'(agg);
      @(posedge clk); #1;
      cfg_load = 0;
   endtask

   task automatic clear_all();
      setcfg(0, 0, 0, 0, 0);
      for (int i = 0; i < N; i++) wr(i, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check(mem_rbit, 1'b0, "R1 reset rdata");
      @(negedge clk); rst_n = 1; running = 1;
      // R1: cells cleared by reset
      rd(0, 0, "R1"); rd(N-1, 0, "R1"); rd(17, 0, "R1");

      // R2: ideal RAM with a mixed pattern
      req = "R2";
      for (int i = 0; i < N; i++) wr(i, logic'((i ^ (i >> 2)) & 1));
      for (int i = 0; i < N; i++) rd(i, logic'((i ^ (i >> 2)) & 1), "R2");
      repeat (4) @(posedge clk);
      #1 check(mem_rbit, logic'(((N-1) ^ ((N-1) >> 2)) & 1), "R2 hold");
      clear_all();

      // R3: stuck-at-1 on cell 5
      req = "R3";
      setcfg(1, 0, 1, 5, 0);
      rd(5, 1, "R3"); wr(5, 0); rd(5, 1, "R3"); rd(6, 0, "R3");
      setcfg(0, 0, 0, 0, 0); rd(5, 1, "R3 stored value");
      wr(5, 0);

      // R4: up transition fault on cell 7
      req = "R4";
      setcfg(2, 0, 0, 7, 0);
      wr(7, 1); rd(7, 0, "R4"); wr(8, 1); rd(8, 1, "R4");

      // R5: down transition fault on cell 9
      req = "R5";
      setcfg(0, 0, 0, 0, 0); wr(9, 1);
      setcfg(3, 0, 0, 9, 0);
      wr(9, 0); rd(9, 1, "R5"); wr(9, 1); rd(9, 1, "R5");

      // R6: inversion coupling, aggressor 3 victim 10
      req = "R6";
      setcfg(4, 0, 0, 10, 3);
      wr(3, 1); rd(10, 1, "R6 rise inverts");
      wr(3, 1); rd(10, 1, "R6 no change");
      wr(3, 0); rd(10, 1, "R6 fall ignored");
      setcfg(4, 1, 0, 10, 3);
      wr(3, 1); rd(10, 1, "R6 rise ignored");
      wr(3, 0); rd(10, 0, "R6 fall inverts");

      // R7: idempotent coupling, aggressor 20 victim 21
      req = "R7";
      setcfg(5, 1, 1, 21, 20);
      wr(20, 1); rd(21, 0, "R7 rise ignored");
      wr(20, 0); rd(21, 1, "R7 fall sets 1");
      setcfg(5, 0, 0, 21, 20);
      wr(20, 1); rd(21, 0, "R7 rise sets 0");
      setcfg(5, 0, 1, 21, 20);
      wr(20, 0); wr(20, 1); rd(21, 1, "R7 rise sets 1");
      setcfg(5, 1, 0, 21, 20);
      wr(20, 0); rd(21, 0, "R7 fall sets 0");

      // R8: bridges between 30 and 31
      req = "R8";
      setcfg(0, 0, 0, 0, 0); wr(30, 1); wr(31, 0); wr(32, 1);
      setcfg(6, 0, 0, 30, 31);
      rd(30, 0, "R8 and"); rd(31, 0, "R8 and"); rd(32, 1, "R8 other");
      setcfg(7, 0, 0, 30, 31);
      rd(30, 1, "R8 or"); rd(31, 1, "R8 or");
      setcfg(0, 0, 0, 0, 0); rd(30, 1, "R8 kept"); rd(31, 0, "R8 kept");

      // R9: alias victim 40 onto cell 41
      req = "R9";
      wr(40, 1); wr(41, 0);
      setcfg(8, 0, 0, 40, 41);
      rd(40, 0, "R9 read alias"); wr(40, 1); rd(41, 1, "R9 write alias");
      wr(40, 0); rd(41, 0, "R9 write alias");
      setcfg(0, 0, 0, 0, 0);
      rd(40, 1, "R9 victim kept"); rd(41, 0, "R9");

      // R10: config applies from next edge; codes above 8 mean none
      req = "R10";
      @(negedge clk);
      cfg_load = 1; cfg_kind = 4'd1; cfg_val = 1; cfg_victim = AW'(50); cfg_aggr = '0;
      mem_en = 1; mem_we = 0; mem_addr = AW'(50);
      @(posedge clk); #1;
      cfg_load = 0; mem_en = 0;
      check(mem_rbit, 0, "R10 same-edge read uses old config");
      rd(50, 1, "R10 new config active");
      setcfg(12, 0, 1, 50, 0);
      rd(50, 0, "R10 bad code is none");
      rd(41, 0, "R10 content kept");

      running = 0;
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule